// File: doc/BRIEF.md
# Conditional Branching Program Counter

This block keeps the 12-bit program memory address for a small processor whose instructions are 16 bits wide. On each clock edge where the advance strobe is high, it looks at the instruction currently presented and chooses the next address. It can step forward by one, add an unsigned forward offset when a conditional branch is taken, or load an absolute jump target. Branch conditions test the zero flag (Z) or the carry flag (C) supplied by the rest of the core.

The all-ones instruction word marks the end of a program. While that word is presented, a halt output is raised and the address stays where it is. The instruction register, the flags and the memory fetch all sit outside the block. The block reads the instruction word only to tell control-flow instructions apart from everything else.

In the bit descriptions below, bit 15 of `instr_i` is the most significant instruction bit. The active-low reset clears the address at once. Its release is synchronised to the clock.

Top module: `flow_pc`

## Requirements
- R1: While `rst_n` is low, `addr_o` reads 0, including a clear applied in the middle of a clock period. After release, the address stays 0 until the first advance.
- R2: On a clock edge where `adv_i` is 0, `addr_o` keeps its value whatever the instruction and flags are.
- R3: An advance on an instruction with bit 15 = 0 (ALU class) or with bits 15:14 = 10 (I/O class) sets the address to the old address plus one.
- R4: An advance on a taken conditional branch sets the address to the old address plus the unsigned offset in bits 9:0. The offset is zero-extended and never subtracted. A conditional branch has bits 15:13 = 111 and bit 10 = 0.
- R5: The branch condition is decided by bits 12:11. Bit 12 picks the flag (0 = Z, 1 = C), and the branch is taken when that flag XOR bit 11 is 1. So 00 means Z=1, 01 means Z=0, 10 means C=1 and 11 means C=0.
- R6: An advance on a conditional branch whose condition fails sets the address to the old address plus one.
- R7: An advance on an instruction with bits 15:12 = 1100 loads bits 11:0 as the new address.
- R8: `halt_o` is 1 exactly while `instr_i` is 16'hFFFF. During that time the address does not change, even with `adv_i` high.
- R9: An advance on an instruction with bits 15:13 = 111 and bit 10 = 1, other than 16'hFFFF, sets the address to the old address plus one.
- R10: Address arithmetic wraps modulo 4096. Stepping from 12'hFFF gives 0, and a branch sum past 12'hFFF keeps only its low 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clear, asserted asynchronously, released synchronously |
| adv_i | input | 1 | Advance strobe: the address updates on edges where this is high |
| instr_i | input | 16 | Current instruction word, bit 15 most significant |
| zf_i | input | 1 | Zero status flag |
| cf_i | input | 1 | Carry status flag |
| addr_o | output | 12 | Program memory address |
| halt_o | output | 1 | End-of-program indication |

## Verification
The hardest case to reach from the ports is a taken branch whose sum passes 12'hFFF. It needs a large offset, a flag that matches the condition code, and an address already near the top of the space. Random stimulus rarely lines up all three. The bench therefore first steers the address with a jump to 12'hFF0, then issues a branch with the maximum offset and a matching flag. All sixteen condition-code and flag pairs are also swept directly before the random phase, which mixes jumps that scatter the address with branches, steps, no-operations and the halt word.

// File: rtl/flow_pc_pkg.sv
package flow_pc_pkg;
  typedef enum logic [1:0] {
    FLOW_STEP   = 2'd0,
    FLOW_BRANCH = 2'd1,
    FLOW_JUMP   = 2'd2,
    FLOW_HALT   = 2'd3
  } flow_e;

  localparam logic [3:0] JUMP_PREFIX   = 4'b1100;
  localparam logic [2:0] BRANCH_PREFIX = 3'b111;
endpackage

// File: rtl/flow_pc_decode.sv
module flow_pc_decode
  import flow_pc_pkg::*;
#(
  parameter int IW   = 16,
  parameter int AW   = 12,
  parameter int OFFW = 10
) (
  input  logic [IW-1:0]   instr,
  output flow_e           kind,
  output logic            cond_sel,
  output logic            cond_inv,
  output logic [OFFW-1:0] offset,
  output logic [AW-1:0]   target
);
  localparam int MSB     = IW - 1;
  localparam int SEL_BIT = MSB - 3;
  localparam int INV_BIT = MSB - 4;
  localparam int CLS_BIT = MSB - 5;

  always_comb begin
    kind = FLOW_STEP;
    if (&instr)
      kind = FLOW_HALT;
    else if (instr[MSB -: 4] == JUMP_PREFIX)
      kind = FLOW_JUMP;
    else if (instr[MSB -: 3] == BRANCH_PREFIX && !instr[CLS_BIT])
      kind = FLOW_BRANCH;
  end

  assign cond_sel = instr[SEL_BIT];
  assign cond_inv = instr[INV_BIT];
  assign offset   = instr[OFFW-1:0];
  assign target   = instr[AW-1:0];
endmodule

// File: rtl/flow_pc_cond.sv
module flow_pc_cond
  import flow_pc_pkg::*;
(
  input  flow_e kind,
  input  logic  zf,
  input  logic  cf,
  input  logic  cond_sel,
  input  logic  cond_inv,
  output logic  take_br
);
  logic flag;

  always_comb begin
    flag    = cond_sel ? cf : zf;
    take_br = (kind == FLOW_BRANCH) && (flag ^ cond_inv);
  end
endmodule

// File: rtl/flow_pc_next.sv
module flow_pc_next
  import flow_pc_pkg::*;
#(
  parameter int AW   = 12,
  parameter int OFFW = 10
) (
  input  logic [AW-1:0]   cur,
  input  flow_e           kind,
  input  logic            take_br,
  input  logic [OFFW-1:0] offset,
  input  logic [AW-1:0]   target,
  output logic [AW-1:0]   nxt
);
  localparam int PADW = AW - OFFW;

  logic [AW-1:0] addend;
  logic [AW-1:0] sum;

  generate
    if (PADW > 0) begin : g_pad
      always_comb addend = take_br ? {{PADW{1'b0}}, offset} : AW'(1);
    end else begin : g_nopad
      always_comb addend = take_br ? offset[AW-1:0] : AW'(1);
    end
  endgenerate

  always_comb begin
    sum = cur + addend;
    nxt = (kind == FLOW_JUMP) ? target : sum;
  end
endmodule

// File: rtl/flow_pc.sv
module flow_pc
  import flow_pc_pkg::*;
#(
  parameter int AW         = 12,
  parameter int IW         = 16,
  parameter int OFFW       = 10,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic [IW-1:0] instr_i,
  input  logic          zf_i,
  input  logic          cf_i,
  output logic [AW-1:0] addr_o,
  output logic          halt_o
);
  logic [RST_STAGES-1:0] sync_q;
  logic                  run_n;

  generate
    for (genvar s = 0; s < RST_STAGES; s++) begin : g_rsync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign run_n = sync_q[RST_STAGES-1];

  flow_e           kind;
  logic            cond_sel;
  logic            cond_inv;
  logic [OFFW-1:0] offset;
  logic [AW-1:0]   target;
  logic            take_br;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   addr_d;
  logic            load_en;

  flow_pc_decode #(.IW(IW), .AW(AW), .OFFW(OFFW)) u_decode (
    .instr    (instr_i),
    .kind     (kind),
    .cond_sel (cond_sel),
    .cond_inv (cond_inv),
    .offset   (offset),
    .target   (target)
  );

  flow_pc_cond u_cond (
    .kind     (kind),
    .zf       (zf_i),
    .cf       (cf_i),
    .cond_sel (cond_sel),
    .cond_inv (cond_inv),
    .take_br  (take_br)
  );

  flow_pc_next #(.AW(AW), .OFFW(OFFW)) u_next (
    .cur     (addr_q),
    .kind    (kind),
    .take_br (take_br),
    .offset  (offset),
    .target  (target),
    .nxt     (addr_d)
  );

  assign halt_o  = (kind == FLOW_HALT);
  assign load_en = adv_i && !halt_o;

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n)       addr_q <= '0;
    else if (load_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/flow_pc_chk.sv
module flow_pc_chk #(
  parameter int AW   = 12,
  parameter int IW   = 16,
  parameter int OFFW = 10
) (
  input logic          clk,
  input logic          run_n,
  input logic          adv_i,
  input logic [IW-1:0] instr_i,
  input logic          zf_i,
  input logic          cf_i,
  input logic [AW-1:0] addr_o,
  input logic          halt_o
);
  localparam int MSB = IW - 1;

  logic is_br;
  logic br_flag;
  assign is_br   = (instr_i[MSB -: 3] == 3'b111) && !instr_i[MSB-5];
  assign br_flag = instr_i[MSB-3] ? cf_i : zf_i;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!run_n)
    !adv_i |=> addr_o == $past(addr_o)); // R2

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!run_n)
    adv_i && !instr_i[MSB] |=> addr_o == $past(addr_o) + AW'(1)); // R3

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!run_n)
    adv_i && instr_i[MSB -: 4] == 4'b1100 |=> addr_o == $past(instr_i[AW-1:0])); // R7

  AST_BRANCH_FWD: assert property (@(posedge clk) disable iff (!run_n)
    adv_i && is_br && (br_flag ^ instr_i[MSB-4])
    |=> addr_o == $past(addr_o) + AW'($past(instr_i[OFFW-1:0]))); // R4

  AST_BRANCH_MISS: assert property (@(posedge clk) disable iff (!run_n)
    adv_i && is_br && !(br_flag ^ instr_i[MSB-4])
    |=> addr_o == $past(addr_o) + AW'(1)); // R6

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!run_n)
    halt_o |=> addr_o == $past(addr_o)); // R8
endmodule

bind flow_pc flow_pc_chk #(.AW(AW), .IW(IW), .OFFW(OFFW)) u_chk (
  .clk     (clk),
  .run_n   (run_n),
  .adv_i   (adv_i),
  .instr_i (instr_i),
  .zf_i    (zf_i),
  .cf_i    (cf_i),
  .addr_o  (addr_o),
  .halt_o  (halt_o)
);

// File: tb/flow_pc_bench.sv
`timescale 1ns/1ps
module flow_pc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i;
  logic [15:0] instr_i;
  logic        zf_i;
  logic        cf_i;
  logic [11:0] addr_o;
  logic        halt_o;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  logic [11:0] exp_addr;

  always #2 clk = ~clk;

  flow_pc u_flow_pc (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .instr_i(instr_i),
    .zf_i(zf_i), .cf_i(cf_i), .addr_o(addr_o), .halt_o(halt_o)
  );

  function automatic logic [11:0] model_next(input logic [11:0] a, input logic [15:0] i,
                                             input logic z, input logic c, input logic adv);
    logic fl;
    if (!adv || i == 16'hFFFF) return a;
    if (i[15:12] == 4'b1100) return i[11:0];
    if (i[15:13] == 3'b111 && !i[10]) begin
      fl = i[12] ? c : z;
      if (fl ^ i[11]) return a + {2'b00, i[9:0]};
    end
    return a + 12'd1;
  endfunction

  function automatic string tag_of(input logic [15:0] i, input logic z, input logic c,
                                   input logic adv);
    logic fl;
    if (i == 16'hFFFF) return "R8";
    if (!adv) return "R2";
    if (i[15:12] == 4'b1100) return "R7";
    if (i[15:13] == 3'b111 && !i[10]) begin
      fl = i[12] ? c : z;
      return (fl ^ i[11]) ? "R4" : "R6";
    end
    if (i[15:13] == 3'b111) return "R9";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves the bench at the next falling edge.
  task automatic drive(input logic [15:0] i, input logic z, input logic c, input logic adv,
                       input string req);
    instr_i = i; zf_i = z; cf_i = c; adv_i = adv;
    #1;
    check((i == 16'hFFFF) ? "R8" : req, {31'd0, halt_o}, {31'd0, i == 16'hFFFF});
    @(posedge clk);
    exp_addr = model_next(exp_addr, i, z, c, adv);
    @(negedge clk);
    check(req, {20'd0, addr_o}, {20'd0, exp_addr});
  endtask

  function automatic logic [15:0] rand_instr();
    logic [15:0] v;
    v = 16'($urandom);
    case ($urandom % 8)
      0:       v[15]    = 1'b0;
      1:       v[15:14] = 2'b10;
      2, 3, 4: begin v[15:13] = 3'b111; v[10] = 1'b0; end
      5:       v[15:12] = 4'b1100;
      6:       begin v[15:13] = 3'b111; v[10] = 1'b1; if (v == 16'hFFFF) v = 16'hFC00; end
      default: v = (($urandom % 2) != 0) ? 16'hFFFF : {1'b0, v[14:0]};
    endcase
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; adv_i = 1'b1; instr_i = 16'h0000; zf_i = 1'b0; cf_i = 1'b0;
    exp_addr = '0;
    repeat (3) @(negedge clk);
    check("R1", {20'd0, addr_o}, 32'd0);
    adv_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {20'd0, addr_o}, 32'd0);

    drive(16'h1234, 1'b0, 1'b0, 1'b1, "R3");
    drive(16'h8ABC, 1'b1, 1'b1, 1'b1, "R3");
    drive(16'hC555, 1'b0, 1'b0, 1'b0, "R2");
    drive(16'hC7F0, 1'b0, 1'b0, 1'b1, "R7");
    for (int cc = 0; cc < 4; cc++)
      for (int zc = 0; zc < 4; zc++)
        drive({3'b111, 2'(cc), 1'b0, 10'h005}, zc[1], zc[0], 1'b1, "R5");
    drive(16'hE400, 1'b1, 1'b1, 1'b1, "R9");
    drive(16'hFC00, 1'b0, 1'b1, 1'b1, "R9");
    drive(16'hFFFF, 1'b0, 1'b0, 1'b1, "R8");
    drive(16'hFFFF, 1'b1, 1'b1, 1'b1, "R8");
    drive(16'hCFFF, 1'b0, 1'b0, 1'b1, "R7");
    drive(16'h0001, 1'b0, 1'b0, 1'b1, "R10");
    drive(16'hCFF0, 1'b0, 1'b0, 1'b1, "R7");
    drive(16'hE3FF, 1'b1, 1'b0, 1'b1, "R10");
    drive(16'hE3FF, 1'b0, 1'b0, 1'b1, "R6");

    for (int n = 0; n < 2000; n++) begin
      logic [15:0] iw;
      logic z, c, a;
      iw = rand_instr();
      z  = 1'($urandom);
      c  = 1'($urandom);
      a  = (($urandom % 5) != 0);
      drive(iw, z, c, a, tag_of(iw, z, c, a));
    end

    adv_i = 1'b1; instr_i = 16'h0000;
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", {20'd0, addr_o}, 32'd0);
    @(negedge clk);
    adv_i = 1'b0; rst_n = 1'b1;
    exp_addr = '0;
    repeat (3) @(negedge clk);
    check("R1", {20'd0, addr_o}, 32'd0);
    drive(16'h0042, 1'b0, 1'b0, 1'b1, "R3");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule